// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a register-driven I2C master that moves one byte at a time for a small processor bus. Software owns the bus by setting a master-select control bit, which produces a start condition. It then picks a direction. In transmit direction, a write to the data register shifts that byte out on SDA and captures the slave's acknowledge. In receive direction, a read of the data register launches nine SCL pulses. Eight of them shift a byte in, and the ninth drives an acknowledge whose polarity was chosen beforehand by a control bit.

A receive read returns the byte gathered by the previous transfer and starts the next one at the same time. A receive loop is therefore one dummy read followed by one read per byte. Every completed byte raises a sticky done flag, which software clears by writing 1 to it. Clearing master-select releases the bus through a stop condition. After that, a data read only returns the last byte.

SCL timing comes from a prescaler register. SDA and SCL are open-drain lines, given here as active-high pull-down enables.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both pull-down enables are 0, and the prescaler (offset 0), control (offset 1), status (offset 2) and data (offset 3) registers all read 0.
- R2: Setting control bit 0 (master-select) while the bus is free pulls SDA low while SCL is still released, then pulls SCL low. Status bit 2 (busy) then reads 1. Status bit 3 (active) is 1 while a start, byte or stop sequence runs.
- R3: Within a byte, consecutive SCL rising edges are 2*(P+1) clock cycles apart, where P is the prescaler value.
- R4: With control bit 1 = 1 (transmit), a data write shifts the byte out MSB first. SDA changes only while SCL is low, and the master releases SDA during the ninth pulse. A data read in transmit direction returns the written byte.
- R5: In transmit, the SDA level seen on the ninth pulse is stored in status bit 1 (1 = not acknowledged).
- R6: Status bit 0 sets when the ninth pulse of a byte completes. Writing 1 to it clears it, and writing 0 leaves it set.
- R7: With control bit 1 = 0 (receive), a data read while the bus is owned and idle produces exactly nine SCL pulses and shifts eight bits in, MSB first.
- R8: Control bit 2 selects the ninth receive bit: 0 pulls SDA low (ACK), 1 leaves it released (NACK).
- R9: A data read after a receive completes returns the received byte and starts the next nine-pulse receive.
- R10: Clearing master-select while the bus is owned and idle pulls SDA low under a low SCL, releases SCL, then releases SDA. Busy then clears and both lines are released. A later data read returns the last byte and produces no SCL pulse.
- R11: Data-register writes and reads issued while status bit 3 is 1 are ignored: the byte in flight, its pulse count and the stored data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected offset |
| sda_in | input | 1 | Level sensed on the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with an 8-bit byte and an 8-bit prescaler. It runs the prescaler at 0, 1, 2 and 3, so that the exact SCL spacing of 2*(P+1) cycles is checked at several settings. At prescaler 0, it sends all 256 byte values and receives all 256 byte values, with the slave's acknowledge varied by data bit. An open-drain line model and a behavioural slave let every SDA and SCL edge be checked, including start, stop and the ACK/NACK ninth bit. Data accesses made in the middle of a byte are checked for no effect through the pulse count and the stored byte.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_A,
    ST_START_B,
    ST_HOLD,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C
  } i2cm_state_e;

  localparam logic [1:0] REG_PRESC = 2'd0;
  localparam logic [1:0] REG_CTRL  = 2'd1;
  localparam logic [1:0] REG_STAT  = 2'd2;
  localparam logic [1:0] REG_DATA  = 2'd3;

  localparam int CTRL_MSEL  = 0;
  localparam int CTRL_DIRTX = 1;
  localparam int CTRL_NACK  = 2;

  localparam int STAT_DONE   = 0;
  localparam int STAT_RXNAK  = 1;
  localparam int STAT_BUSY   = 2;
  localparam int STAT_ACTIVE = 3;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt;

  assign tick = (cnt >= presc);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R3: a phase end is followed by at least one more cycle unless P is 0
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && presc != '0) |=> (!tick || presc == '0));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              msel,
  input  logic              tx_go,
  input  logic              rx_go,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              nack_sel,
  input  logic              sda_in,
  output logic              restart,
  output logic              eng_idle,
  output logic              eng_hold,
  output logic              done_pulse,
  output logic              done_rx,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_nack,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int IDX_W = $clog2(DATA_W + 1);

  i2cm_state_e       st, st_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic              samp, samp_n;
  logic              xmit, xmit_n;
  logic              nakd, nakd_n;
  logic              rxn_n;
  logic              scl_n, sda_n;

  always_comb begin
    st_n       = st;
    idx_n      = idx;
    sh_n       = sh;
    samp_n     = samp;
    xmit_n     = xmit;
    nakd_n     = nakd;
    rxn_n      = rx_nack;
    restart    = 1'b0;
    done_pulse = 1'b0;
    case (st)
      ST_IDLE:    if (msel) begin st_n = ST_START_A; restart = 1'b1; end
      ST_START_A: if (tick) st_n = ST_START_B;
      ST_START_B: if (tick) st_n = ST_HOLD;
      ST_HOLD: begin
        if (!msel) begin
          st_n    = ST_STOP_A;
          restart = 1'b1;
        end else if (tx_go || rx_go) begin
          st_n    = ST_BIT_LO;
          restart = 1'b1;
          idx_n   = IDX_W'(DATA_W);
          sh_n    = tx_go ? tx_byte : '0;
          xmit_n  = tx_go;
          nakd_n  = nack_sel;
        end
      end
      ST_BIT_LO: if (tick) begin st_n = ST_BIT_HI; samp_n = sda_in; end
      ST_BIT_HI: begin
        if (tick) begin
          if (idx == '0) begin
            st_n       = ST_HOLD;
            done_pulse = 1'b1;
            if (xmit) rxn_n = samp;
          end else begin
            st_n  = ST_BIT_LO;
            idx_n = idx - 1'b1;
            sh_n  = {sh[DATA_W-2:0], samp};
          end
        end
      end
      ST_STOP_A: if (tick) st_n = ST_STOP_B;
      ST_STOP_B: if (tick) st_n = ST_STOP_C;
      ST_STOP_C: if (tick) st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  // line levels for the state being entered, so pins and state change together
  always_comb begin
    scl_n = 1'b0;
    sda_n = 1'b0;
    case (st_n)
      ST_START_A: sda_n = 1'b1;
      ST_START_B, ST_HOLD, ST_STOP_A: begin scl_n = 1'b1; sda_n = 1'b1; end
      ST_STOP_B:  sda_n = 1'b1;
      ST_BIT_LO, ST_BIT_HI: begin
        scl_n = (st_n == ST_BIT_LO);
        if (idx_n != '0) sda_n = xmit_n ? !sh_n[DATA_W-1] : 1'b0;
        else             sda_n = xmit_n ? 1'b0 : !nakd_n;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      idx     <= '0;
      sh      <= '0;
      samp    <= 1'b0;
      xmit    <= 1'b0;
      nakd    <= 1'b0;
      rx_nack <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      st      <= st_n;
      idx     <= idx_n;
      sh      <= sh_n;
      samp    <= samp_n;
      xmit    <= xmit_n;
      nakd    <= nakd_n;
      rx_nack <= rxn_n;
      scl_oe  <= scl_n;
      sda_oe  <= sda_n;
    end
  end

  assign eng_idle = (st == ST_IDLE);
  assign eng_hold = (st == ST_HOLD);
  assign done_rx  = done_pulse && !xmit;
  assign rx_byte  = sh;

  // R4: SDA never moves during a high SCL phase of a data bit
  a_r4_sda_stable_high: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BIT_HI && $past(st) == ST_BIT_HI) |-> $stable(sda_oe));
  // R2: start phase has SDA pulled and SCL released
  a_r2_start_order: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START_A) |-> (sda_oe && !scl_oe));
  // R10: free bus means both lines released
  a_r10_idle_free: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!scl_oe && !sda_oe));
  // R7: never asked to send and receive at once
  a_r7_single_go: assert property (@(posedge clk) disable iff (rst)
    !(tx_go && rx_go));
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               eng_idle,
  input  logic               eng_hold,
  input  logic               done_pulse,
  input  logic               done_rx,
  input  logic [DATA_W-1:0]  rx_byte,
  input  logic               rx_nack,
  output logic [PRESC_W-1:0] presc,
  output logic               msel,
  output logic               dir_tx,
  output logic               nack_sel,
  output logic               tx_go,
  output logic               rx_go,
  output logic [DATA_W-1:0]  tx_byte
);
  logic              done_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_any, rd_any, active;

  assign wr_any  = bus_sel && bus_wr;
  assign rd_any  = bus_sel && !bus_wr;
  assign active  = !eng_idle && !eng_hold;
  assign tx_go   = wr_any && bus_addr == REG_DATA && dir_tx && msel && eng_hold;
  assign rx_go   = rd_any && bus_addr == REG_DATA && !dir_tx && msel && eng_hold;
  assign tx_byte = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc    <= '0;
      msel     <= 1'b0;
      dir_tx   <= 1'b0;
      nack_sel <= 1'b0;
      done_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      if (wr_any && bus_addr == REG_PRESC) presc <= bus_wdata[PRESC_W-1:0];
      if (wr_any && bus_addr == REG_CTRL) begin
        msel     <= bus_wdata[CTRL_MSEL];
        dir_tx   <= bus_wdata[CTRL_DIRTX];
        nack_sel <= bus_wdata[CTRL_NACK];
      end
      if (done_pulse) done_q <= 1'b1;
      else if (wr_any && bus_addr == REG_STAT && bus_wdata[STAT_DONE]) done_q <= 1'b0;
      if (tx_go)        data_q <= bus_wdata;
      else if (done_rx) data_q <= rx_byte;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_PRESC: bus_rdata[PRESC_W-1:0] = presc;
      REG_CTRL: begin
        bus_rdata[CTRL_MSEL]  = msel;
        bus_rdata[CTRL_DIRTX] = dir_tx;
        bus_rdata[CTRL_NACK]  = nack_sel;
      end
      REG_STAT: begin
        bus_rdata[STAT_DONE]   = done_q;
        bus_rdata[STAT_RXNAK]  = rx_nack;
        bus_rdata[STAT_BUSY]   = !eng_idle;
        bus_rdata[STAT_ACTIVE] = active;
      end
      default: bus_rdata = data_q;
    endcase
  end

  // R6: write-one clears the done flag when no completion coincides
  a_r6_done_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_any && bus_addr == REG_STAT && bus_wdata[STAT_DONE] && !done_pulse) |=> !done_q);
  // R11: data writes during a sequence leave the stored byte alone
  a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_any && bus_addr == REG_DATA && active && !done_rx) |=> $stable(data_q));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DATA_W  = 8,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [PRESC_W-1:0] presc;
  logic               msel, dir_tx, nack_sel, tx_go, rx_go;
  logic [DATA_W-1:0]  tx_byte, rx_byte;
  logic               tick, restart, eng_idle, eng_hold;
  logic               done_pulse, done_rx, rx_nack;

  i2cm_regs #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_idle(eng_idle), .eng_hold(eng_hold),
    .done_pulse(done_pulse), .done_rx(done_rx),
    .rx_byte(rx_byte), .rx_nack(rx_nack),
    .presc(presc), .msel(msel), .dir_tx(dir_tx), .nack_sel(nack_sel),
    .tx_go(tx_go), .rx_go(rx_go), .tx_byte(tx_byte)
  );

  i2cm_tick #(.PRESC_W(PRESC_W)) u_tick (
    .clk(clk), .rst(rst), .restart(restart), .presc(presc), .tick(tick)
  );

  i2cm_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .tick(tick), .msel(msel),
    .tx_go(tx_go), .rx_go(rx_go), .tx_byte(tx_byte), .nack_sel(nack_sel),
    .sda_in(sda_in), .restart(restart),
    .eng_idle(eng_idle), .eng_hold(eng_hold),
    .done_pulse(done_pulse), .done_rx(done_rx),
    .rx_byte(rx_byte), .rx_nack(rx_nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int PW = 8;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic sda_in, scl_oe, sda_oe;

  i2c_byte_master #(.DATA_W(DW), .PRESC_W(PW)) dut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_err = 0, cyc = 0;

  // open-drain line and behavioural slave
  logic slv_en = 1'b0, slv_tx = 1'b0, slv_ack = 1'b0;
  logic [7:0] slv_byte = '0;
  int drv_idx = 0, bcnt = 0;
  logic slv_pull, scl_l, sda_l;
  assign slv_pull = slv_en && (slv_tx ? ((drv_idx < 8) ? !slv_byte[3'(7 - drv_idx)] : 1'b0)
                                      : (drv_idx == 8 && slv_ack));
  assign scl_l  = !scl_oe;
  assign sda_l  = !(sda_oe || slv_pull);
  assign sda_in = sda_l;

  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] rec_byte = '0;
  logic rec_ack = 1'b0;
  int start_cnt = 0, stop_cnt = 0, rise_cnt = 0, last_rise = 0;
  int per_min = 1000000, per_max = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (p_scl && scl_l && p_sda && !sda_l) begin
      start_cnt++; bcnt = 0; drv_idx = 0;
    end
    if (p_scl && scl_l && !p_sda && sda_l) stop_cnt++;
    if (!p_scl && scl_l) begin
      rise_cnt++;
      if (bcnt != 0) begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      if (bcnt < 8) rec_byte = {rec_byte[6:0], sda_l};
      else begin
        rec_ack = sda_l;
        if (slv_tx && sda_l) slv_en = 1'b0;
      end
      bcnt = (bcnt == 8) ? 0 : bcnt + 1;
    end
    if (p_scl && !scl_l) drv_idx = bcnt;
    p_scl = scl_l;
    p_sda = sda_l;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  always @(posedge clk) if (cyc == WD_LIMIT) begin
    n_err++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
    summary();
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic wait_stat(input int bitn, input logic val, input string req);
    logic [7:0] s;
    bit ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      bus_read(2'd2, s);
      if (s[bitn] == val) begin ok = 1'b1; break; end
    end
    check(req, int'(ok), 1);
  endtask

  task automatic tx_session(input int p, input int nb);
    logic [7:0] s, d, b;
    int st0, sp0, r0;
    bus_write(2'd0, 8'(p));
    st0 = start_cnt;
    bus_write(2'd1, 8'h03);
    wait_stat(3, 1'b0, "R2 start completes");
    check("R2 one start seen", start_cnt - st0, 1);
    bus_read(2'd2, s);
    check("R2 busy after start", int'(s[2]), 1);
    check("R2 SCL held low", int'(scl_oe), 1);
    slv_tx = 1'b0; slv_en = 1'b1;
    for (int k = 0; k < nb; k++) begin
      b = 8'((k * 37 + 11) & 255);
      slv_ack = b[0] ^ b[3];
      per_min = 1000000; per_max = 0; r0 = rise_cnt;
      bus_write(2'd3, b);
      if (p == 3 && k == 1) begin
        bus_write(2'd3, ~b);
        bus_read(2'd3, d);
      end
      wait_stat(0, 1'b1, "R6 done sets");
      check("R4 byte on SDA", int'(rec_byte), int'(b));
      check("R4 ninth bit released by master", int'(rec_ack), int'(!slv_ack));
      bus_read(2'd2, s);
      check("R5 ack status", int'(s[1]), int'(!slv_ack));
      check("R3 min SCL period", per_min, 2 * (p + 1));
      check("R3 max SCL period", per_max, 2 * (p + 1));
      check("R11 nine pulses per byte", rise_cnt - r0, 9);
      bus_read(2'd3, d);
      check("R4 R11 data readback", int'(d), int'(b));
      if (k == 0) begin
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, s);
        check("R6 write 0 keeps flag", int'(s[0]), 1);
      end
      bus_write(2'd2, 8'h01);
      bus_read(2'd2, s);
      check("R6 write 1 clears flag", int'(s[0]), 0);
    end
    sp0 = stop_cnt;
    bus_write(2'd1, 8'h02);
    wait_stat(2, 1'b0, "R10 busy clears");
    check("R10 one stop seen", stop_cnt - sp0, 1);
    check("R10 SCL released", int'(scl_oe), 0);
    check("R10 SDA released", int'(sda_oe), 0);
  endtask

  function automatic logic [7:0] rxval(input int k);
    return 8'((k * 53 + 7) & 255);
  endfunction

  task automatic rx_session(input int p, input int nb, input bit extra_rd);
    logic [7:0] s, d;
    int st0, sp0, r0;
    bus_write(2'd0, 8'(p));
    st0 = start_cnt;
    bus_write(2'd1, (nb == 1) ? 8'h05 : 8'h01);
    wait_stat(3, 1'b0, "R2 start completes");
    check("R2 one start seen", start_cnt - st0, 1);
    slv_tx = 1'b1; slv_en = 1'b1;
    slv_byte = rxval(0);
    r0 = rise_cnt;
    bus_read(2'd3, d);
    if (extra_rd) bus_read(2'd3, d);
    for (int k = 0; k < nb; k++) begin
      wait_stat(0, 1'b1, "R6 done sets");
      check("R7 nine pulses", rise_cnt - r0, 9);
      check("R7 slave byte on line", int'(rec_byte), int'(rxval(k)));
      check("R8 ninth bit", int'(rec_ack), (k == nb - 1) ? 1 : 0);
      bus_write(2'd2, 8'h01);
      if (k < nb - 1) begin
        slv_byte = rxval(k + 1);
        if (k + 1 == nb - 1) bus_write(2'd1, 8'h05);
        r0 = rise_cnt;
        bus_read(2'd3, d);
        check("R9 read returns byte", int'(d), int'(rxval(k)));
        if (extra_rd) bus_read(2'd3, d);
      end
    end
    sp0 = stop_cnt;
    bus_write(2'd1, 8'h04);
    wait_stat(2, 1'b0, "R10 busy clears");
    check("R10 stop after receive", stop_cnt - sp0, 1);
    r0 = rise_cnt;
    bus_read(2'd3, d);
    check("R10 last byte after stop", int'(d), int'(rxval(nb - 1)));
    repeat (20) @(negedge clk);
    check("R10 no pulses after stop read", rise_cnt - r0, 0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 scl_oe reset", int'(scl_oe), 0);
    check("R1 sda_oe reset", int'(sda_oe), 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), d);
      check("R1 register reset", int'(d), 0);
    end
    tx_session(0, 256);
    tx_session(1, 6);
    tx_session(3, 6);
    rx_session(0, 256, 1'b0);
    rx_session(2, 4, 1'b1);
    rx_session(1, 1, 1'b0);
    summary();
    $finish;
  end
endmodule